// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Controller

This controller fetches one cache line from a lower memory port after a miss. The miss request carries two things: the line number and the index of the word the processor is waiting for. The controller then issues one word request per accepted handshake on the memory request port. It stores every returned word in a line buffer at the slot given by the index that travels with the word. The awaited word goes back to the processor on a dedicated early-data port in the same cycle it arrives from memory. The rest of the line keeps streaming in after that.

A per-miss mode bit chooses the fetch order. In wrapped mode the awaited word is requested first, and the order then wraps around the end of the line. In sequential mode the words are requested from slot 0 upward. The early-data forward works the same way in both modes. A one-cycle line-complete pulse tells the surrounding cache that the full line is present on the line-data output. The controller then accepts the next miss.

Top module: `cwf_line_refill`

## Requirements
- R1: `miss_ready` is 1 only while the controller is idle. A miss is accepted on a cycle with `miss_valid` and `miss_ready` both 1. A `miss_valid` raised while a refill is in progress has no effect on the requests issued or on the assembled line.
- R2: With `miss_cwf` = 1 and awaited index k, the word requests carry the indices k, k+1, ..., WORDS-1, 0, ..., k-1, in that order.
- R3: With `miss_cwf` = 0, the word requests carry the indices 0, 1, ..., WORDS-1 in that order, whatever k is.
- R4: Each request address is the byte address of the requested word. The line number sits in the top bits, the word index sits just below it (bits [5:3] with the defaults), and the byte offset bits are 0.
- R5: A request that is not accepted (`mem_req_ready` = 0) stays valid with an unchanged index and address until it is accepted.
- R6: Every returned word is placed in the line buffer at `mem_rsp_idx`. With line-complete, word i appears on `line_data` bits [WORD_W*i+WORD_W-1 : WORD_W*i].
- R7: `early_valid` is 1 in exactly the cycle where the response carrying the awaited index is presented, and `early_data` equals that response's data. This happens exactly once per refill, in either mode.
- R8: After the awaited word has been forwarded, the controller keeps issuing requests until all WORDS words have been requested, exactly once each.
- R9: `line_done` is a one-cycle pulse in the cycle after the last of the WORDS responses is taken. In the next cycle `miss_ready` is 1 again.
- R10: After reset, `miss_ready` is 1 and `mem_req_valid`, `early_valid` and `line_done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Controller idle, miss can be taken |
| miss_line | input | LINE_W | Line number of the missed line |
| miss_word | input | IDX_W | Index of the awaited word |
| miss_cwf | input | 1 | 1: wrapped order from awaited word, 0: sequential from word 0 |
| mem_req_valid | output | 1 | Word request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Byte address of requested word |
| mem_req_idx | output | IDX_W | Word index of the request |
| mem_rsp_valid | input | 1 | Returned word present |
| mem_rsp_idx | input | IDX_W | Slot of the returned word |
| mem_rsp_data | input | WORD_W | Returned word |
| early_valid | output | 1 | Awaited word forwarded this cycle |
| early_data | output | WORD_W | Awaited word |
| line_done | output | 1 | Whole line assembled (one cycle) |
| line_data | output | WORDS*WORD_W | Assembled line |

## Verification
The bench builds the controller with its defaults: 32-bit addresses and eight 64-bit words per line, which gives a three-bit word index. With these values, every wrap point of the wrapped order can be reached: an awaited index of 0 gives no wrap, and an awaited index of 7 sends the second request straight to slot 0. Request acceptance is throttled at random and the response latency varies, so the awaited word may arrive early or late in the refill. A stray miss raised during a refill probes the busy path, and back-to-back refills probe the turnaround after line-complete.

// File: rtl/refill_pkg.sv
package refill_pkg;
   typedef enum logic [1:0] {
      RF_IDLE = 2'd0,
      RF_FILL = 2'd1,
      RF_DONE = 2'd2
   } refill_state_e;
endpackage

// File: rtl/refill_order_gen.sv
// Computes the word index of the n-th request of a refill.
module refill_order_gen #(
   parameter int WORDS = 8,
   parameter int IDX_W = 3
) (
   input  logic [IDX_W-1:0] crit_idx,
   input  logic             wrap_mode,
   input  logic [IDX_W:0]   issue_cnt,
   output logic [IDX_W-1:0] req_idx
);
   logic [IDX_W-1:0] seq_idx;
   logic [IDX_W-1:0] wrap_idx;

   assign seq_idx = issue_cnt[IDX_W-1:0];

   generate
      if ((WORDS & (WORDS - 1)) == 0) begin : g_pow2
         // natural truncation performs the modulo
         assign wrap_idx = crit_idx + seq_idx;
      end else begin : g_mod
         logic [IDX_W:0] sum;
         assign sum      = {1'b0, crit_idx} + {1'b0, seq_idx};
         assign wrap_idx = (sum >= (IDX_W+1)'(WORDS)) ?
                           IDX_W'(sum - (IDX_W+1)'(WORDS)) : sum[IDX_W-1:0];
      end
   endgenerate

   assign req_idx = wrap_mode ? wrap_idx : seq_idx;
endmodule

// File: rtl/refill_line_buf.sv
// Word-addressed line storage with a per-slot arrival mask.
module refill_line_buf #(
   parameter int WORDS  = 8,
   parameter int WORD_W = 64,
   parameter int IDX_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [WORD_W-1:0]       wr_data,
   output logic [WORDS*WORD_W-1:0] line_q,
   output logic [WORDS-1:0]        fill_mask
);
   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_slot
         logic hit;
         assign hit = wr_en && (wr_idx == IDX_W'(w));

         always_ff @(posedge clk) begin
            if (hit) line_q[w*WORD_W +: WORD_W] <= wr_data;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   fill_mask[w] <= 1'b0;
            else if (clr) fill_mask[w] <= 1'b0;
            else if (hit) fill_mask[w] <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cwf_line_refill.sv
module cwf_line_refill
   import refill_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 64,
   parameter int WORDS  = 8,
   localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int BYTE_OFF = $clog2(WORD_W / 8),
   localparam int LINE_W   = ADDR_W - IDX_W - BYTE_OFF
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    miss_valid,
   output logic                    miss_ready,
   input  logic [LINE_W-1:0]       miss_line,
   input  logic [IDX_W-1:0]        miss_word,
   input  logic                    miss_cwf,
   output logic                    mem_req_valid,
   input  logic                    mem_req_ready,
   output logic [ADDR_W-1:0]       mem_req_addr,
   output logic [IDX_W-1:0]        mem_req_idx,
   input  logic                    mem_rsp_valid,
   input  logic [IDX_W-1:0]        mem_rsp_idx,
   input  logic [WORD_W-1:0]       mem_rsp_data,
   output logic                    early_valid,
   output logic [WORD_W-1:0]       early_data,
   output logic                    line_done,
   output logic [WORDS*WORD_W-1:0] line_data
);
   localparam int CNT_W = IDX_W + 1;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORDS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORDS - 1);

   initial begin : p_param_chk
      assert (WORDS >= 2) else $fatal(1, "WORDS must be at least 2");
      assert (WORD_W >= 8 && (WORD_W % 8) == 0 && (WORD_W & (WORD_W - 1)) == 0)
         else $fatal(1, "WORD_W must be a power-of-two byte multiple");
      assert (LINE_W >= 1) else $fatal(1, "ADDR_W too small for the line");
   end

   refill_state_e    state_q;
   logic [LINE_W-1:0] line_q;
   logic [IDX_W-1:0]  crit_q;
   logic              wrap_q;
   logic [CNT_W-1:0]  issue_cnt;
   logic [CNT_W-1:0]  rcv_cnt;
   logic              fwd_done_q;
   logic [WORDS-1:0]  fill_mask;

   logic accept;
   logic req_fire;
   logic rsp_take;

   assign accept   = miss_valid && (state_q == RF_IDLE);
   assign req_fire = mem_req_valid && mem_req_ready;
   assign rsp_take = mem_rsp_valid && (state_q == RF_FILL);

   // control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= RF_IDLE;
         line_q     <= '0;
         crit_q     <= '0;
         wrap_q     <= 1'b0;
         issue_cnt  <= '0;
         rcv_cnt    <= '0;
         fwd_done_q <= 1'b0;
      end else begin
         unique case (state_q)
            RF_IDLE: begin
               if (accept) begin
                  state_q    <= RF_FILL;
                  line_q     <= miss_line;
                  crit_q     <= miss_word;
                  wrap_q     <= miss_cwf;
                  issue_cnt  <= '0;
                  rcv_cnt    <= '0;
                  fwd_done_q <= 1'b0;
               end
            end
            RF_FILL: begin
               if (req_fire) issue_cnt <= issue_cnt + 1'b1;
               if (early_valid) fwd_done_q <= 1'b1;
               if (rsp_take) begin
                  rcv_cnt <= rcv_cnt + 1'b1;
                  if (rcv_cnt == CNT_LAST) state_q <= RF_DONE;
               end
            end
            RF_DONE: state_q <= RF_IDLE;
            default: state_q <= RF_IDLE;
         endcase
      end
   end

   // request side
   refill_order_gen #(
      .WORDS(WORDS),
      .IDX_W(IDX_W)
   ) u_order (
      .crit_idx (crit_q),
      .wrap_mode(wrap_q),
      .issue_cnt(issue_cnt),
      .req_idx  (mem_req_idx)
   );

   assign mem_req_valid = (state_q == RF_FILL) && (issue_cnt < CNT_FULL);
   assign mem_req_addr  = {line_q, mem_req_idx, {BYTE_OFF{1'b0}}};

   // response side
   refill_line_buf #(
      .WORDS (WORDS),
      .WORD_W(WORD_W),
      .IDX_W (IDX_W)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .wr_en    (rsp_take),
      .wr_idx   (mem_rsp_idx),
      .wr_data  (mem_rsp_data),
      .line_q   (line_data),
      .fill_mask(fill_mask)
   );

   assign early_valid = rsp_take && (mem_rsp_idx == crit_q) && !fwd_done_q;
   assign early_data  = mem_rsp_data;
   assign line_done   = (state_q == RF_DONE);
   assign miss_ready  = (state_q == RF_IDLE);
endmodule

// File: rtl/refill_checker.sv
module refill_checker #(
   parameter int WORDS = 8,
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             miss_valid,
   input logic             miss_ready,
   input logic [IDX_W-1:0] miss_word,
   input logic             miss_cwf,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [IDX_W-1:0] mem_req_idx,
   input logic             early_valid,
   input logic             line_done,
   input logic [WORDS-1:0] fill_mask
);
   logic [IDX_W-1:0] c_crit;
   logic             c_wrap;
   int unsigned      c_issued;
   int unsigned      c_fwd;
   logic [IDX_W-1:0] c_exp_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_crit   <= '0;
         c_wrap   <= 1'b0;
         c_issued <= 0;
         c_fwd    <= 0;
      end else if (miss_valid && miss_ready) begin
         c_crit   <= miss_word;
         c_wrap   <= miss_cwf;
         c_issued <= 0;
         c_fwd    <= 0;
      end else begin
         if (mem_req_valid && mem_req_ready) c_issued <= c_issued + 1;
         if (early_valid) c_fwd <= c_fwd + 1;
      end
   end

   assign c_exp_idx = c_wrap ? IDX_W'((int'(c_crit) + int'(c_issued)) % WORDS)
                             : IDX_W'(c_issued);

   assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !miss_ready);

   assert_order_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_idx == c_exp_idx) && (c_issued < WORDS));

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_idx));

   assert_single_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
      early_valid |-> (c_fwd == 0));

   assert_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> (c_fwd == 1) && (c_issued == WORDS) && (&fill_mask));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |=> !line_done && miss_ready);
endmodule

bind cwf_line_refill refill_checker #(
   .WORDS(WORDS),
   .IDX_W(IDX_W)
) u_refill_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .miss_valid   (miss_valid),
   .miss_ready   (miss_ready),
   .miss_word    (miss_word),
   .miss_cwf     (miss_cwf),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_idx  (mem_req_idx),
   .early_valid  (early_valid),
   .line_done    (line_done),
   .fill_mask    (fill_mask)
);

// File: tb/test_cwf_line_refill.sv
`timescale 1ns/1ps
module test_cwf_line_refill;
   localparam int ADDR_W = 32;
   localparam int WORD_W = 64;
   localparam int WORDS  = 8;
   localparam int IDX_W  = 3;
   localparam int LINE_W = ADDR_W - 6;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    miss_valid = 1'b0;
   logic                    miss_ready;
   logic [LINE_W-1:0]       miss_line = '0;
   logic [IDX_W-1:0]        miss_word = '0;
   logic                    miss_cwf = 1'b0;
   logic                    mem_req_valid;
   logic                    mem_req_ready = 1'b0;
   logic [ADDR_W-1:0]       mem_req_addr;
   logic [IDX_W-1:0]        mem_req_idx;
   logic                    mem_rsp_valid = 1'b0;
   logic [IDX_W-1:0]        mem_rsp_idx = '0;
   logic [WORD_W-1:0]       mem_rsp_data = '0;
   logic                    early_valid;
   logic [WORD_W-1:0]       early_data;
   logic                    line_done;
   logic [WORDS*WORD_W-1:0] line_data;

   always #2 clk = ~clk;

   cwf_line_refill #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)
   ) i_cwf_line_refill (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
      .miss_word(miss_word), .miss_cwf(miss_cwf),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_idx(mem_req_idx),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_idx(mem_rsp_idx),
      .mem_rsp_data(mem_rsp_data),
      .early_valid(early_valid), .early_data(early_data),
      .line_done(line_done), .line_data(line_data)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   // scoreboard state
   int          exp_q[$];
   int          pend_idx[$];
   int          pend_due[$];
   bit          active = 0;
   logic [LINE_W-1:0] cur_line;
   int          cur_crit;
   int          rcvd;
   int          fwd_cnt;
   bit          done_due;
   bit          prev_stall;
   logic [IDX_W-1:0]  prev_idx;
   logic [ADDR_W-1:0] prev_addr;

   function automatic logic [WORD_W-1:0] pat(input logic [LINE_W-1:0] ln, input int w);
      logic [31:0] a;
      a = {ln, 3'(w), 3'b000};
      return {a ^ 32'hC3A5_5A3C, a};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [WORDS*WORD_W-1:0] act,
                      input logic [WORDS*WORD_W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // responder and monitor
   always @(negedge clk) begin
      cyc++;
      mem_req_ready = ($urandom % 4) != 0;
      if (pend_idx.size() > 0 && pend_due[0] <= cyc) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_idx   = IDX_W'(pend_idx[0]);
         mem_rsp_data  = pat(cur_line, pend_idx[0]);
         pend_idx.delete(0);
         pend_due.delete(0);
      end else begin
         mem_rsp_valid = 1'b0;
      end
      #1;
      if (active) begin
         chk(!miss_ready, "R1 busy miss_ready", miss_ready, 0);
         if (prev_stall)
            chk(mem_req_valid && mem_req_idx == prev_idx && mem_req_addr == prev_addr,
                "R5 held request", {mem_req_valid, mem_req_idx}, {1'b1, prev_idx});
         if (mem_req_valid && mem_req_ready) begin
            if (exp_q.size() == 0) begin
               chk(0, "R8 extra request", mem_req_idx, 0);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk(mem_req_idx == IDX_W'(e), "R2/R3 order", mem_req_idx, e);
               chk(mem_req_addr == {cur_line, 3'(e), 3'b000}, "R4 address",
                   mem_req_addr, {cur_line, 3'(e), 3'b000});
               pend_idx.push_back(e);
               pend_due.push_back(cyc + 1 + int'($urandom % 3));
            end
         end
         prev_stall = mem_req_valid && !mem_req_ready;
         prev_idx   = mem_req_idx;
         prev_addr  = mem_req_addr;
         begin
            bit exp_e;
            exp_e = mem_rsp_valid && (int'(mem_rsp_idx) == cur_crit);
            chk(early_valid == exp_e, "R7 early_valid timing", early_valid, exp_e);
            if (early_valid) begin
               fwd_cnt++;
               chk(early_data == pat(cur_line, cur_crit), "R7 early_data",
                   early_data, pat(cur_line, cur_crit));
            end
         end
         chk(line_done == done_due, "R9 line_done timing", line_done, done_due);
         if (line_done) begin
            logic [WORDS*WORD_W-1:0] exp_line;
            for (int w = 0; w < WORDS; w++) exp_line[w*WORD_W +: WORD_W] = pat(cur_line, w);
            chk(line_data == exp_line, "R6 line contents", line_data, exp_line);
            chk(fwd_cnt == 1, "R7 one forward per refill", fwd_cnt, 1);
            chk(exp_q.size() == 0, "R8 all words requested", exp_q.size(), 0);
            active   = 0;
            done_due = 0;
         end
         if (mem_rsp_valid) begin
            rcvd++;
            if (rcvd == WORDS) done_due = 1;
         end
      end else begin
         prev_stall = 0;
      end
   end

   task automatic run_refill(input logic [LINE_W-1:0] ln, input int k, input bit cwf,
                             input bit stray);
      @(negedge clk);
      while (!miss_ready) @(negedge clk);
      miss_valid = 1'b1;
      miss_line  = ln;
      miss_word  = IDX_W'(k);
      miss_cwf   = cwf;
      cur_line   = ln;
      cur_crit   = k;
      rcvd       = 0;
      fwd_cnt    = 0;
      done_due   = 0;
      exp_q.delete();
      for (int i = 0; i < WORDS; i++) exp_q.push_back(cwf ? (k + i) % WORDS : i);
      @(negedge clk);
      active = 1;
      if (stray) begin
         // R1: a second miss during the refill must be ignored
         miss_line = ~ln;
         miss_word = IDX_W'(k + 3);
         miss_cwf  = ~cwf;
         repeat (3) @(negedge clk);
      end
      miss_valid = 1'b0;
      while (active) @(negedge clk);
      @(negedge clk);
      chk(miss_ready, "R9 idle after line_done", miss_ready, 1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      #1;
      chk(miss_ready && !mem_req_valid && !early_valid && !line_done, "R10 reset state",
          {miss_ready, mem_req_valid, early_valid, line_done}, 4'b1000);
      rst_n = 1'b1;
      run_refill(26'h0012345, 0, 1'b1, 1'b0);   // R2 no wrap
      run_refill(26'h3ABCDEF, 5, 1'b1, 1'b0);   // R2 wrap mid-line
      run_refill(26'h0000001, 7, 1'b1, 1'b1);   // R2 wrap at end, R1 stray miss
      run_refill(26'h1555555, 3, 1'b0, 1'b0);   // R3 sequential, awaited mid-line
      run_refill(26'h2AAAAAA, 7, 1'b0, 1'b1);   // R3 awaited word last
      run_refill(26'h0F0F0F0, 0, 1'b0, 1'b0);   // R3 awaited word first
      for (int t = 0; t < 6; t++)
         run_refill(LINE_W'($urandom), int'($urandom % WORDS), 1'($urandom), 1'b0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule